// File: doc/BRIEF.md
# Nibble-assembled instruction memory

This block is a small instruction store with ten locations of 8 bits each, at addresses 0 to 9. A producer sends each instruction word as two 4-bit transfers. The low-nibble strobe puts the input nibble into the opcode half, bits [3:0], of a write buffer. On a later cycle, the high-nibble strobe puts the input nibble into the operand half, bits [7:4]. When the word in the buffer is complete, a write enable stores all 8 bits at the location given by a 4-bit program counter.

A read enable copies the addressed location into a registered 8-bit output buffer. A decoder turns the program counter and the two enables into one write line and one read line for each location. At most one of these twenty lines is active in any cycle.

Any program counter value from 10 to 15 selects no line. The stored words and the output buffer are then left unchanged. The program counter logic and the control sequencer sit outside this block.

Top module: `nibble_imem`

## Requirements
- R1: After reset, the output buffer is 0x00, every location holds 0x00 and the write buffer holds 0x00.
- R2: A clock edge with `ld_lo` high loads `nib_in` into write-buffer bits [3:0] and leaves bits [7:4] unchanged.
- R3: A clock edge with `ld_hi` high loads `nib_in` into write-buffer bits [7:4] and leaves bits [3:0] unchanged.
- R4: A clock edge with `wr_en` high and `pc` in 0..9 stores the write buffer, as it was before that edge, into location `pc`. All other locations keep their contents.
- R5: A clock edge with `rd_en` high, `wr_en` low and `pc` in 0..9 loads location `pc` into `dout`. The new value is visible after that edge.
- R6: When `pc` is 10 to 15, no location and not `dout` change, whatever the enables are.
- R7: When both enables are low, `dout` holds its value.
- R8: When both enables are high, only the write takes place and `dout` holds its value.
- R9: The decoder never asserts more than one of its twenty read and write lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| nib_in | input | 4 | Input nibble for the write buffer |
| ld_lo | input | 1 | Load `nib_in` into the opcode half (bits [3:0]) |
| ld_hi | input | 1 | Load `nib_in` into the operand half (bits [7:4]) |
| pc | input | 4 | Location address; valid values are 0..9 |
| rd_en | input | 1 | Read enable |
| wr_en | input | 1 | Write enable |
| dout | output | 8 | Registered output buffer |

## Verification
The bench goes after five corner cases:
- **Out-of-range addresses.** The bench writes and reads at addresses 10 to 15, then reads back every location. A decoder that folded these addresses onto a real location would corrupt a stored word or change `dout`.
- **Half loads.** Each half is reloaded alone and the word is then written. Logic that cleared or shifted the other nibble would show up as a wrong upper or lower half in the word read back.
- **Buffer reloaded on the write edge.** A write and a new nibble load can fall on the same edge. If the design stored the freshly loaded value instead of the buffer as it stood before the edge, the stored word would be wrong.
- **Both enables high.** A design that let the read through in this case would change `dout` when it must hold.
- **Reset.** All ten locations are read back right after reset to show they start at zero.

// File: rtl/imem_pkg.sv
package imem_pkg;
    localparam int IM_DEPTH = 10;
    localparam int IM_AW    = 4;
    localparam int IM_DW    = 8;
endpackage

// File: rtl/imem_wbuf.sv
module imem_wbuf #(
    parameter int DW = imem_pkg::IM_DW,
    localparam int NW = DW / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NW-1:0] nib_in,
    input  logic          ld_lo,
    input  logic          ld_hi,
    output logic [DW-1:0] word
);
    typedef struct packed {
        logic [NW-1:0] hi;
        logic [NW-1:0] lo;
    } wbuf_t;

    wbuf_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (ld_lo) s_d.lo = nib_in;
        if (ld_hi) s_d.hi = nib_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign word = s_q;

    // R2
    lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_lo |=> word[NW-1:0] == $past(nib_in));
    // R3
    hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_hi && !ld_lo) |=> $stable(word[NW-1:0]));
    // R3
    hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_hi |=> word[DW-1:NW] == $past(nib_in));
    // R2
    lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_lo && !ld_hi) |=> $stable(word[DW-1:NW]));
endmodule

// File: rtl/imem_decode.sv
module imem_decode #(
    parameter int DEPTH = imem_pkg::IM_DEPTH,
    parameter int AW    = imem_pkg::IM_AW
) (
    input  logic [AW-1:0]    pc,
    input  logic             rd_en,
    input  logic             wr_en,
    output logic [DEPTH-1:0] rd_line,
    output logic [DEPTH-1:0] wr_line
);
    logic [DEPTH-1:0] hit;

    for (genvar g = 0; g < DEPTH; g++) begin : g_loc
        assign hit[g]     = (pc == AW'(g));
        assign wr_line[g] = hit[g] & wr_en;
        assign rd_line[g] = hit[g] & rd_en & ~wr_en;
    end

    // R9
    one_line_chk: assert final ($onehot0({rd_line, wr_line}));
endmodule

// File: rtl/imem_store.sv
module imem_store #(
    parameter int DEPTH = imem_pkg::IM_DEPTH,
    parameter int DW    = imem_pkg::IM_DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] rd_line,
    input  logic [DEPTH-1:0] wr_line,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    dout
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [DW-1:0]            obuf;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_line[i]) s_d.mem[i] = wdata;
            if (rd_line[i]) s_d.obuf = s_q.mem[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dout = s_q.obuf;

    // R6
    no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_line == '0) |=> $stable(s_q.mem));
    // R7
    no_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_line == '0) |=> $stable(dout));

    for (genvar g = 0; g < DEPTH; g++) begin : g_chk
        // R4
        write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_line[g] |=> s_q.mem[g] == $past(wdata));
        // R5
        read_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_line[g] |=> dout == $past(s_q.mem[g]));
    end
endmodule

// File: rtl/nibble_imem.sv
module nibble_imem #(
    parameter int DEPTH = imem_pkg::IM_DEPTH,
    parameter int AW    = imem_pkg::IM_AW,
    parameter int DW    = imem_pkg::IM_DW,
    localparam int NW   = DW / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NW-1:0] nib_in,
    input  logic          ld_lo,
    input  logic          ld_hi,
    input  logic [AW-1:0] pc,
    input  logic          rd_en,
    input  logic          wr_en,
    output logic [DW-1:0] dout
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DW-1:0]    wbuf_word;
    logic [DEPTH-1:0] rd_line;
    logic [DEPTH-1:0] wr_line;

    imem_wbuf #(.DW(DW)) u_wbuf (
        .clk(clk), .rst_n(rst_n), .nib_in(nib_in),
        .ld_lo(ld_lo), .ld_hi(ld_hi), .word(wbuf_word)
    );

    imem_decode #(.DEPTH(DEPTH), .AW(AW)) u_dec (
        .pc(pc), .rd_en(rd_en), .wr_en(wr_en),
        .rd_line(rd_line), .wr_line(wr_line)
    );

    imem_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .rd_line(rd_line), .wr_line(wr_line),
        .wdata(wbuf_word), .dout(dout)
    );

    // R6
    oor_no_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc > LAST) |-> (rd_line == '0 && wr_line == '0));
    // R6
    oor_dout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc > LAST) |=> $stable(dout));
    // R8
    both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en) |=> $stable(dout));
endmodule

// File: tb/test_nibble_imem.sv
module test_nibble_imem;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] nib_in = '0;
    logic       ld_lo = 1'b0, ld_hi = 1'b0;
    logic [3:0] pc = '0;
    logic       rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0] dout;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [7:0] m_mem [10];
    logic [7:0] m_wbuf;
    logic [7:0] m_dout;

    always #5 clk = ~clk;

    nibble_imem i_nibble_imem (
        .clk(clk), .rst_n(rst_n), .nib_in(nib_in), .ld_lo(ld_lo), .ld_hi(ld_hi),
        .pc(pc), .rd_en(rd_en), .wr_en(wr_en), .dout(dout)
    );

    function automatic bit in_range(logic [3:0] a);
        return a <= 4'd9;
    endfunction

    function automatic string tag_of(bit r, bit w, logic [3:0] a);
        if (!in_range(a) && (r || w)) return "R6";
        if (r && w) return "R8";
        if (w) return "R4";
        if (r) return "R5";
        return "R7";
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: dout=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock cycle: drive at negedge, update model at posedge, sample after.
    task automatic step(bit lo, bit hi, logic [3:0] n, logic [3:0] a, bit r, bit w, string req);
        @(negedge clk);
        ld_lo = lo; ld_hi = hi; nib_in = n; pc = a; rd_en = r; wr_en = w;
        @(posedge clk);
        if (w && in_range(a)) m_mem[a] = m_wbuf;
        else if (r && in_range(a)) m_dout = m_mem[a];
        if (lo) m_wbuf[3:0] = n;
        if (hi) m_wbuf[7:4] = n;
        #1;
        check(req, dout, m_dout);
    endtask

    task automatic read_all(string req);
        for (int k = 0; k < 10; k++) step(0, 0, 4'h0, 4'(k), 1, 0, req);
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int k = 0; k < 10; k++) m_mem[k] = 8'h00;
        m_wbuf = 8'h00;
        m_dout = 8'h00;
        repeat (3) @(negedge clk);
        #1;
        check("R1", dout, 8'h00);
        rst_n = 1'b1;
        read_all("R1");
        // Empty write buffer after reset must store zero.
        step(0, 0, 4'h0, 4'd7, 0, 1, "R1");
        step(0, 0, 4'h0, 4'd7, 1, 0, "R1");
        // Full word assembly.
        step(1, 0, 4'hA, 4'd0, 0, 0, "R2");
        step(0, 1, 4'h5, 4'd0, 0, 0, "R3");
        step(0, 0, 4'h0, 4'd3, 0, 1, "R4");
        step(0, 0, 4'h0, 4'd3, 1, 0, "R4");
        check("R4", dout, 8'h5A);
        // Low half only: high half kept.
        step(1, 0, 4'h6, 4'd0, 0, 0, "R2");
        step(0, 0, 4'h0, 4'd4, 0, 1, "R2");
        step(0, 0, 4'h0, 4'd4, 1, 0, "R2");
        check("R2", dout, 8'h56);
        // High half only: low half kept.
        step(0, 1, 4'h9, 4'd0, 0, 0, "R3");
        step(0, 0, 4'h0, 4'd5, 0, 1, "R3");
        step(0, 0, 4'h0, 4'd5, 1, 0, "R3");
        check("R3", dout, 8'h96);
        // Write on the same edge as a reload stores the old buffer.
        step(1, 1, 4'h3, 4'd9, 0, 1, "R4");
        step(0, 0, 4'h0, 4'd9, 1, 0, "R4");
        check("R4", dout, 8'h96);
        // Out-of-range addresses touch nothing.
        step(0, 0, 4'h0, 4'd10, 0, 1, "R6");
        step(0, 0, 4'h0, 4'd15, 0, 1, "R6");
        step(0, 0, 4'h0, 4'd12, 1, 0, "R6");
        check("R6", dout, 8'h96);
        read_all("R6");
        // Both enables: write only, output holds.
        step(0, 0, 4'h0, 4'd3, 0, 0, "R7");
        step(0, 0, 4'h0, 4'd3, 1, 1, "R8");
        check("R8", dout, m_dout);
        step(0, 0, 4'h0, 4'd3, 1, 0, "R8");
        check("R8", dout, 8'h33);
        // Random traffic.
        for (int t = 0; t < 3000; t++) begin
            bit lo = 1'($urandom_range(0, 3) == 0);
            bit hi = 1'($urandom_range(0, 3) == 0);
            logic [3:0] n = 4'($urandom);
            logic [3:0] a = ($urandom_range(0, 4) == 0) ? 4'($urandom_range(10, 15))
                                                        : 4'($urandom_range(0, 9));
            bit w = 1'($urandom_range(0, 3) == 0);
            bit r = 1'($urandom_range(0, 1));
            step(lo, hi, n, a, r, w, tag_of(r, w, a));
        end
        read_all("R4");
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: cycles=200000 expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule